// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Supervisor

This block is the digital core of a system reset supervisor. It watches two active-low push-button lines and a digital undervoltage flag from an external comparator, and it drives a single active-low reset output. A press of both buttons together resets the system only after the pair has been held for a selectable multi-second setup time. A short press, or a press of one button, is ignored, so the same buttons can serve as an ordinary interrupt source for the processor.

The output reset pulse has a fixed length, chosen by an option bit. The same pulse generator also produces the power-on reset and the undervoltage reset. All asynchronous inputs pass through two-flop synchronizers. Internal time is counted in ticks of a prescaler that divides the system clock. The setup times and timeouts are parameters given in ticks, so a bench can shrink them.

Top module: `rsv_supervisor`

## Requirements
- R1: When both button pins go low together, `rst_n` goes low after exactly S*CLK_PER_TICK+2 rising clock edges, counted from the first edge after the change. S is the selected setup time in ticks; the 2 extra edges are the synchronizer.
- R2: If either button is released before the setup time ends, the count clears and `rst_n` does not change. A new press must then wait the full setup time again.
- R3: `dly_sel` sets the setup time. Code 2'b00 selects SETUP_LO_TICKS, 2'b01 (the open level) selects SETUP_MID_TICKS, and 2'b10 or 2'b11 selects SETUP_HI_TICKS.
- R4: A button-triggered pulse holds `rst_n` low for exactly T*CLK_PER_TICK cycles. T is HOLD_SHORT_TICKS when `long_to` is 0 and HOLD_LONG_TICKS when it is 1.
- R5: A single continuous hold of both buttons gives exactly one pulse. Both buttons must be released before a new setup count can start.
- R6: `rst_n` goes low on the third rising edge after `uv_low` rises and stays low while the flag is high. After the flag falls, `rst_n` rises T*CLK_PER_TICK+2 edges after the change.
- R7: `rst_n` is low while `rst` is high. It rises T*CLK_PER_TICK edges after the first edge with `rst` low.
- R8: If `uv_low` is raised during a button-triggered pulse, the pulse is extended, and its timeout restarts from the release of `uv_low` as in R6.
- R9: Holding only one button, for any length of time, never asserts reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| btn_a_n | input | 1 | First push-button, active low, asynchronous |
| btn_b_n | input | 1 | Second push-button, active low, asynchronous |
| uv_low | input | 1 | Supply-below-threshold flag from comparator, active high, asynchronous |
| dly_sel | input | 2 | Setup time select (three-level pin stand-in) |
| long_to | input | 1 | Reset timeout option: 0 short, 1 long |
| rst_n | output | 1 | System reset, active low |

## Verification
Two of the block's functions can act in the same cycles. The undervoltage load can arrive while a button-triggered timeout is still counting down. The bench provokes this by raising `uv_low` a few cycles after the button pulse has started, while both buttons are still held. It then checks, on every cycle, that the pulse does not end on its original schedule, that it ends exactly one timeout plus synchronizer delay after the flag falls, and that the buttons still held do not start a second pulse.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    DLY_LO     = 2'b00,
    DLY_MID    = 2'b01,
    DLY_HI     = 2'b10,
    DLY_HI_ALT = 2'b11
  } dly_sel_e;

  // Counter width able to hold values 0..n
  function automatic int cnt_width(input int n);
    int w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ff1, ff2;
    always_ff @(posedge clk) begin
      if (rst) begin
        ff1 <= RST_VAL[i];
        ff2 <= RST_VAL[i];
      end else begin
        ff1 <= d_async[i];
        ff2 <= ff1;
      end
    end
    assign q_sync[i] = ff2;
  end

endmodule

// File: rtl/rsv_ticker.sv
module rsv_ticker #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);

  localparam int W = rsv_pkg::cnt_width(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rsv_setup_timer.sv
module rsv_setup_timer #(
  parameter int S_LO  = 2000,
  parameter int S_MID = 6000,
  parameter int S_HI  = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_a_s,
  input  logic       btn_b_s,
  input  logic [1:0] sel,
  input  logic       tick,
  output logic       run,
  output logic       fire
);

  import rsv_pkg::*;

  localparam int S_MAX = (S_LO > S_MID) ? ((S_LO > S_HI) ? S_LO : S_HI)
                                        : ((S_MID > S_HI) ? S_MID : S_HI);
  localparam int CW = cnt_width(S_MAX);
  localparam logic [CW-1:0] L_LO  = CW'(S_LO - 1);
  localparam logic [CW-1:0] L_MID = CW'(S_MID - 1);
  localparam logic [CW-1:0] L_HI  = CW'(S_HI - 1);
  localparam logic [CW-1:0] C_MAX = CW'(S_MAX);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          armed;
  logic          both_low;
  logic          both_up;

  assign both_low = !btn_a_s && !btn_b_s;
  assign both_up  = btn_a_s && btn_b_s;
  assign run      = both_low && armed;

  always_comb begin
    case (dly_sel_e'(sel))
      DLY_LO:  last = L_LO;
      DLY_MID: last = L_MID;
      default: last = L_HI;
    endcase
  end

  assign fire = run && tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      if (both_up) armed <= 1'b1;
      if (fire) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (!run) begin
        cnt <= '0;
      end else if (tick && cnt < C_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= C_MAX);

  // R5
  rearm_block_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !armed);

  // R1
  fire_both_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(!btn_a_s && !btn_b_s));

  // R5
  rearm_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(both_up));

endmodule

// File: rtl/rsv_pulse_gen.sv
module rsv_pulse_gen #(
  parameter int T_SHORT = 140,
  parameter int T_LONG  = 240
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic fire,
  input  logic long_to,
  input  logic tick,
  output logic load,
  output logic busy
);

  localparam int T_MAX = (T_SHORT > T_LONG) ? T_SHORT : T_LONG;
  localparam int CW = rsv_pkg::cnt_width(T_MAX);
  localparam logic [CW-1:0] L_SHORT = CW'(T_SHORT - 1);
  localparam logic [CW-1:0] L_LONG  = CW'(T_LONG - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign load = hold || fire;
  assign last = long_to ? L_LONG : L_SHORT;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && tick) begin
      if (cnt >= last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4
  release_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tick));

  // R6
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> busy);

  // R4
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cnt == '0));

endmodule

// File: rtl/rsv_supervisor.sv
module rsv_supervisor #(
  parameter int CLK_PER_TICK     = 50000,
  parameter int SETUP_LO_TICKS   = 2000,
  parameter int SETUP_MID_TICKS  = 6000,
  parameter int SETUP_HI_TICKS   = 10000,
  parameter int HOLD_SHORT_TICKS = 140,
  parameter int HOLD_LONG_TICKS  = 240
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_a_n,
  input  logic       btn_b_n,
  input  logic       uv_low,
  input  logic [1:0] dly_sel,
  input  logic       long_to,
  output logic       rst_n
);

  localparam int NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b011;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] syn;
  logic btn_a_s, btn_b_s, uv_s;
  logic setup_run, setup_tick, fire;
  logic pulse_load, pulse_busy, pulse_tick;

  assign raw_in  = {uv_low, btn_b_n, btn_a_n};
  assign btn_a_s = syn[0];
  assign btn_b_s = syn[1];
  assign uv_s    = syn[2];

  rsv_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_in),
    .q_sync  (syn)
  );

  rsv_ticker #(.DIV(CLK_PER_TICK)) u_setup_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (!setup_run),
    .run  (setup_run),
    .tick (setup_tick)
  );

  rsv_setup_timer #(
    .S_LO  (SETUP_LO_TICKS),
    .S_MID (SETUP_MID_TICKS),
    .S_HI  (SETUP_HI_TICKS)
  ) u_setup (
    .clk     (clk),
    .rst     (rst),
    .btn_a_s (btn_a_s),
    .btn_b_s (btn_b_s),
    .sel     (dly_sel),
    .tick    (setup_tick),
    .run     (setup_run),
    .fire    (fire)
  );

  rsv_ticker #(.DIV(CLK_PER_TICK)) u_pulse_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (pulse_load),
    .run  (pulse_busy),
    .tick (pulse_tick)
  );

  rsv_pulse_gen #(
    .T_SHORT (HOLD_SHORT_TICKS),
    .T_LONG  (HOLD_LONG_TICKS)
  ) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .hold    (uv_s),
    .fire    (fire),
    .long_to (long_to),
    .tick    (pulse_tick),
    .load    (pulse_load),
    .busy    (pulse_busy)
  );

  assign rst_n = !pulse_busy;

  // R6
  uv_out_chk: assert property (@(posedge clk) disable iff (rst)
    uv_s |=> !rst_n);

  // R1
  fire_out_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !rst_n);

  // R9
  single_btn_chk: assert property (@(posedge clk) disable iff (rst)
    (btn_a_s || btn_b_s) |-> !fire);

endmodule

// File: tb/rsv_supervisor_test.sv
module rsv_supervisor_test;

  localparam int DIV = 3;
  localparam int SL = 2, SM = 3, SH = 4;
  localparam int TS = 2, TL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_a_n = 1'b1, btn_b_n = 1'b1, uv_low = 1'b0, long_to = 1'b0;
  logic [1:0] dly_sel = 2'b00;
  logic rst_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rsv_supervisor #(
    .CLK_PER_TICK(DIV), .SETUP_LO_TICKS(SL), .SETUP_MID_TICKS(SM),
    .SETUP_HI_TICKS(SH), .HOLD_SHORT_TICKS(TS), .HOLD_LONG_TICKS(TL)
  ) uut (
    .clk(clk), .rst(rst), .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
    .uv_low(uv_low), .dly_sel(dly_sel), .long_to(long_to), .rst_n(rst_n)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rst_n=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Runs 'total' edges; rst_n expected low for edge index k in [lo_s, lo_e)
  task automatic window(input int total, input int lo_s, input int lo_e,
                        input string tag);
    for (int k = 1; k <= total; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(rst_n, !(k >= lo_s && k < lo_e), tag);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int s_ticks, t_ticks, f;
    repeat (3) @(negedge clk);
    check(rst_n, 1'b0, "R7 reset state");
    rst = 1'b0;
    window(TS*DIV + 3, 0, TS*DIV, "R7 power-up release");

    // Sweep select codes and timeout option: R1 R3 R4 R5
    for (int to = 0; to < 2; to++) begin
      for (int s = 0; s < 4; s++) begin
        dly_sel = 2'(s);
        long_to = 1'(to);
        window(3, 0, 0, "R3 idle");
        s_ticks = (s == 0) ? SL : (s == 1) ? SM : SH;
        t_ticks = (to == 1) ? TL : TS;
        f = s_ticks*DIV + 2;
        btn_a_n = 1'b0;
        btn_b_n = 1'b0;
        window(f + t_ticks*DIV + 2*s_ticks*DIV, f, f + t_ticks*DIV,
               "R1 R3 R4 R5 pulse");
        btn_a_n = 1'b1;
        btn_b_n = 1'b1;
        window(5, 0, 0, "R5 after release");
      end
    end

    // R2: early release of one button clears the count
    dly_sel = 2'b00;
    long_to = 1'b0;
    f = SL*DIV + 2;
    btn_a_n = 1'b0;
    btn_b_n = 1'b0;
    window(3, 0, 0, "R2 partial hold");
    btn_b_n = 1'b1;
    window(3, 0, 0, "R2 one released");
    btn_b_n = 1'b0;
    window(f + TS*DIV + 2, f, f + TS*DIV, "R2 full restart");
    btn_a_n = 1'b1;
    btn_b_n = 1'b1;
    window(5, 0, 0, "R2 idle");

    // R9: one button only
    btn_a_n = 1'b0;
    window(4*SH*DIV, 0, 0, "R9 button a alone");
    btn_a_n = 1'b1;
    btn_b_n = 1'b0;
    window(4*SH*DIV, 0, 0, "R9 button b alone");
    btn_b_n = 1'b1;
    window(4, 0, 0, "R9 idle");

    // R6: undervoltage
    uv_low = 1'b1;
    window(8, 3, 1000, "R6 assert");
    uv_low = 1'b0;
    window(2 + TS*DIV + 3, 0, 2 + TS*DIV, "R6 release");

    // R8: undervoltage during a button pulse
    dly_sel = 2'b00;
    long_to = 1'b1;
    f = SL*DIV + 2;
    btn_a_n = 1'b0;
    btn_b_n = 1'b0;
    window(f + 2, f, 1000, "R8 pulse start");
    uv_low = 1'b1;
    window(4, 0, 1000, "R8 flag high");
    uv_low = 1'b0;
    window(2 + TL*DIV + 4, 0, 2 + TL*DIV, "R8 restarted timeout");
    btn_a_n = 1'b1;
    btn_b_n = 1'b1;
    window(5, 0, 0, "R8 idle");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule